// File: doc/BRIEF.md
# Floating-Point System Register Bank

This block holds the control and identification registers of a floating-point coprocessor and serves register moves to and from the integer core. A request carries a move direction, a 4-bit register selector, a 4-bit destination index, a write data word, a 4-bit condition code, a condition-passed input and a privileged-mode input. The block decides whether the move takes effect. A write updates the selected register on the clock edge where the request is sampled. A read returns its data, registered, one cycle later.

The status/control register and the constant identification and feature registers are open to any mode. The exception register and the two instruction registers answer only when the privileged-mode input is high. Otherwise the access is dropped without any response. A read of the status register aimed at destination 15 does not return a data word. Instead it raises a separate strobe that carries the four top status bits, which the core loads into its N, Z, C and V flags.

Top module: `fpsys_regbank`

## Requirements
- R1: Selector 1 (status/control) is written with `req_wdata` and read back in any mode; the value read is the last value written.
- R2: A read of selector 0 returns the `ID_VALUE` parameter, selector 7 returns `FEAT0_VALUE` (default 0x11111111) and selector 6 returns `FEAT1_VALUE` (default 0), in any mode.
- R3: Selectors 8 (exception), 9 (instruction 1) and 10 (instruction 2) are read and written only while `priv_mode` is 1. With `priv_mode` 0, a read gives no response and a write leaves the register unchanged.
- R4: A read of selector 1 with `req_dest` equal to 15 raises `flag_valid` instead of `rd_valid`. `flag_nzcv` bit 3 carries status bit 31 (N), bit 2 bit 30 (Z), bit 1 bit 29 (C) and bit 0 bit 28 (V).
- R5: After reset, instruction 1 holds 0xEE000A00, instruction 2 holds 0, and the status and exception registers hold 0.
- R6: A request executes only when `req_cond` equals 4'hE or `cond_pass` is 1. Otherwise it writes nothing and gives no response.
- R7: Writes to selectors 0, 6 and 7 have no effect. Selectors 2 to 5 and 11 to 15 are ignored for both reads and writes, with no response.
- R8: An executed read sets `rd_valid` for exactly one cycle, the cycle after the request, together with `rd_data` and `rd_dest` (the request's destination). A write, an ignored request, or a cycle with `req_valid` 0 leaves `rd_valid` and `flag_valid` at 0 and `rd_data` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A move request is present this cycle |
| req_write | input | 1 | 1: move to the bank; 0: move from the bank |
| req_sel | input | 4 | Register selector |
| req_dest | input | 4 | Integer destination index for reads |
| req_wdata | input | 32 | Write data |
| req_cond | input | 4 | Condition code; 4'hE means always |
| cond_pass | input | 1 | Condition evaluated true by the core |
| priv_mode | input | 1 | Core is in a privileged mode |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Read data |
| rd_dest | output | 4 | Destination index for the read data |
| flag_valid | output | 1 | Flag transfer is valid |
| flag_nzcv | output | 4 | N, Z, C, V values for the core |

## Verification
The assertions assume that `req_valid` and the request fields are defined on every sampled edge once reset is released. They also assume that a read of selector 1 to destination 15 always means a flag transfer, never a data move. The bench drives every field from a seeded random source, with no constraints beyond that, so privilege, condition code, selector and destination cover their full ranges. It also mixes in idle cycles. Directed sequences cover the reset values, the flag transfer, and unprivileged writes that are followed by privileged read-back.

// File: rtl/fpsys_pkg.sv
package fpsys_pkg;
   // selector codes decoded by the integer core's move operations
   localparam logic [3:0] SEL_IDENT  = 4'd0;
   localparam logic [3:0] SEL_STATUS = 4'd1;
   localparam logic [3:0] SEL_FEAT1  = 4'd6;
   localparam logic [3:0] SEL_FEAT0  = 4'd7;
   localparam logic [3:0] SEL_EXCEPT = 4'd8;
   localparam logic [3:0] SEL_INST1  = 4'd9;
   localparam logic [3:0] SEL_INST2  = 4'd10;
   localparam logic [3:0] DEST_FLAGS = 4'd15;

   localparam int NUM_SLOTS = 4;
   typedef enum logic [1:0] {
      SLOT_STATUS = 2'd0,
      SLOT_EXCEPT = 2'd1,
      SLOT_INST1  = 2'd2,
      SLOT_INST2  = 2'd3
   } slot_e;
endpackage

// File: rtl/fpsys_access_gate.sv
module fpsys_access_gate
   import fpsys_pkg::*;
#(
   parameter int         SEL_W       = 4,
   parameter logic [3:0] COND_ALWAYS = 4'hE
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [SEL_W-1:0]     req_sel,
   input  logic [3:0]           req_dest,
   input  logic [3:0]           req_cond,
   input  logic                 cond_pass,
   input  logic                 priv_mode,
   output logic [NUM_SLOTS-1:0] wr_en,
   output logic                 rd_hit,
   output logic                 flag_hit
);
   logic   exec;
   logic   open;
   logic   writable;
   logic   to_flags;
   slot_e  slot;

   generate
      if (SEL_W != 4) begin : g_bad_sel
         $error("fpsys_access_gate: SEL_W must be 4");
      end
   endgenerate

   assign exec = req_valid && ((req_cond == COND_ALWAYS) || cond_pass);

   always_comb begin
      open     = 1'b0;
      writable = 1'b0;
      slot     = SLOT_STATUS;
      unique case (req_sel)
         SEL_STATUS: begin open = 1'b1; writable = 1'b1; end
         SEL_IDENT, SEL_FEAT0, SEL_FEAT1: open = 1'b1;
         SEL_EXCEPT: begin open = priv_mode; writable = 1'b1; slot = SLOT_EXCEPT; end
         SEL_INST1:  begin open = priv_mode; writable = 1'b1; slot = SLOT_INST1;  end
         SEL_INST2:  begin open = priv_mode; writable = 1'b1; slot = SLOT_INST2;  end
         default: ;
      endcase
   end

   assign to_flags = (req_sel == SEL_STATUS) && (req_dest == DEST_FLAGS);

   always_comb begin
      wr_en = '0;
      if (exec && req_write && open && writable) wr_en[slot] = 1'b1;
   end

   assign rd_hit   = exec && !req_write && open && !to_flags;
   assign flag_hit = exec && !req_write && to_flags;
endmodule

// File: rtl/fpsys_slot_regs.sv
module fpsys_slot_regs
   import fpsys_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter logic [DATA_W-1:0] INST1_RST = 32'hEE000A00,
   parameter logic [DATA_W-1:0] INST2_RST = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SLOTS-1:0]    wr_en,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       q [NUM_SLOTS]
);
   function automatic logic [DATA_W-1:0] rst_of(int k);
      if (k == int'(SLOT_INST1)) return INST1_RST;
      if (k == int'(SLOT_INST2)) return INST2_RST;
      return '0;
   endfunction

   generate
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
         localparam logic [DATA_W-1:0] RST_V = rst_of(k);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[k] <= RST_V;
            else if (wr_en[k]) q[k] <= wdata;
         end

         // R7 / R3: a slot changes only on its own enabled write
         p_hold_unwritten_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[k] |=> $stable(q[k]));
      end
   endgenerate
endmodule

// File: rtl/fpsys_regbank.sv
module fpsys_regbank
   import fpsys_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          SEL_W       = 4,
   parameter logic [3:0]  COND_ALWAYS = 4'hE,
   parameter logic [31:0] ID_VALUE    = 32'h4D0F_0A21,
   parameter logic [31:0] FEAT0_VALUE = 32'h1111_1111,
   parameter logic [31:0] FEAT1_VALUE = 32'h0000_0000,
   parameter logic [31:0] INST1_RST   = 32'hEE00_0A00,
   parameter logic [31:0] INST2_RST   = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [3:0]        req_dest,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [3:0]        req_cond,
   input  logic              cond_pass,
   input  logic              priv_mode,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [3:0]        rd_dest,
   output logic              flag_valid,
   output logic [3:0]        flag_nzcv
);
   localparam int FLAG_LSB = DATA_W - 4;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("fpsys_regbank: DATA_W must be 32");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] wr_en;
   logic                 rd_hit;
   logic                 flag_hit;
   logic [DATA_W-1:0]    slot_q [NUM_SLOTS];
   logic [DATA_W-1:0]    rd_mux;

   fpsys_access_gate #(.SEL_W(SEL_W), .COND_ALWAYS(COND_ALWAYS)) i_gate (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_sel   (req_sel),
      .req_dest  (req_dest),
      .req_cond  (req_cond),
      .cond_pass (cond_pass),
      .priv_mode (priv_mode),
      .wr_en     (wr_en),
      .rd_hit    (rd_hit),
      .flag_hit  (flag_hit)
   );

   fpsys_slot_regs #(.DATA_W(DATA_W), .INST1_RST(INST1_RST), .INST2_RST(INST2_RST)) i_slots (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (req_wdata),
      .q     (slot_q)
   );

   always_comb begin
      case (req_sel)
         SEL_IDENT:  rd_mux = ID_VALUE;
         SEL_STATUS: rd_mux = slot_q[SLOT_STATUS];
         SEL_FEAT1:  rd_mux = FEAT1_VALUE;
         SEL_FEAT0:  rd_mux = FEAT0_VALUE;
         SEL_EXCEPT: rd_mux = slot_q[SLOT_EXCEPT];
         SEL_INST1:  rd_mux = slot_q[SLOT_INST1];
         SEL_INST2:  rd_mux = slot_q[SLOT_INST2];
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         rd_dest    <= '0;
         flag_valid <= 1'b0;
         flag_nzcv  <= '0;
      end else begin
         rd_valid   <= rd_hit;
         rd_data    <= rd_hit ? rd_mux : '0;
         rd_dest    <= rd_hit ? req_dest : '0;
         flag_valid <= flag_hit;
         flag_nzcv  <= flag_hit ? slot_q[SLOT_STATUS][FLAG_LSB +: 4] : 4'h0;
      end
   end

   // R3: unprivileged access to the guarded selectors gives no response
   p_unpriv_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !priv_mode && (req_sel >= SEL_EXCEPT) && (req_sel <= SEL_INST2))
      |=> (!rd_valid && !flag_valid));

   // R6: failed condition gives no response
   p_cond_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_cond != COND_ALWAYS) && !cond_pass) |=> (!rd_valid && !flag_valid));

   // R4: status read to destination 15 becomes a flag transfer
   p_flag_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_cond == COND_ALWAYS) &&
       (req_sel == SEL_STATUS) && (req_dest == DEST_FLAGS)) |=> (flag_valid && !rd_valid));

   // R8: no request, no response
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rd_valid && !flag_valid && rd_data == '0));

   // R8: a write never produces read data
   p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (!rd_valid && !flag_valid));
endmodule

// File: tb/test_fpsys_regbank.sv
`timescale 1ns/1ps
module test_fpsys_regbank;
   localparam logic [31:0] ID_V = 32'h4D0F_0A21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, cond_pass = 1'b0, priv_mode = 1'b0;
   logic [3:0]  req_sel = '0, req_dest = '0, req_cond = 4'hE;
   logic [31:0] req_wdata = '0;
   logic        rd_valid, flag_valid;
   logic [31:0] rd_data;
   logic [3:0]  rd_dest, flag_nzcv;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_st = 0, m_ex = 0, m_i1 = 32'hEE000A00, m_i2 = 0;

   always #4 clk = ~clk;

   fpsys_regbank i_fpsys_regbank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .req_dest(req_dest), .req_wdata(req_wdata),
      .req_cond(req_cond), .cond_pass(cond_pass), .priv_mode(priv_mode),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_dest(rd_dest),
      .flag_valid(flag_valid), .flag_nzcv(flag_nzcv));

   function automatic string tag_of(logic v, logic w, logic [3:0] s, logic [3:0] d,
                                    logic [3:0] c, logic cp, logic pr);
      if (!v) return "R8";
      if (c != 4'hE && !cp) return "R6";
      if (s >= 8 && s <= 10) return pr ? "R3 priv" : "R3";
      if (s == 1 && !w && d == 15) return "R4";
      if (s == 1) return "R1";
      if (s == 0 || s == 6 || s == 7) return w ? "R7" : "R2";
      return "R7";
   endfunction

   // expected response: kind 0 none, 1 data, 2 flags
   function automatic int exp_kind(logic v, logic w, logic [3:0] s, logic [3:0] d,
                                   logic [3:0] c, logic cp, logic pr);
      if (!v || (c != 4'hE && !cp) || w) return 0;
      if (s == 1) return (d == 15) ? 2 : 1;
      if (s == 0 || s == 6 || s == 7) return 1;
      if (s >= 8 && s <= 10 && pr) return 1;
      return 0;
   endfunction

   function automatic logic [31:0] exp_val(logic [3:0] s);
      case (s)
         4'd0: return ID_V;
         4'd1: return m_st;
         4'd6: return 32'h0;
         4'd7: return 32'h11111111;
         4'd8: return m_ex;
         4'd9: return m_i1;
         4'd10: return m_i2;
         default: return 32'h0;
      endcase
   endfunction

   task automatic req(logic v, logic w, logic [3:0] s, logic [3:0] d, logic [31:0] wd,
                      logic [3:0] c, logic cp, logic pr);
      int k;
      logic [31:0] ev;
      string t;
      k  = exp_kind(v, w, s, d, c, cp, pr);
      ev = exp_val(s);
      t  = tag_of(v, w, s, d, c, cp, pr);
      req_valid = v; req_write = w; req_sel = s; req_dest = d; req_wdata = wd;
      req_cond = c; cond_pass = cp; priv_mode = pr;
      if (v && w && (c == 4'hE || cp)) begin
         if (s == 1) m_st = wd;
         else if (pr && s == 8) m_ex = wd;
         else if (pr && s == 9) m_i1 = wd;
         else if (pr && s == 10) m_i2 = wd;
      end
      @(negedge clk);
      checks++;
      if (k == 1) begin
         if (!(rd_valid && !flag_valid && rd_data == ev && rd_dest == d)) begin
            errors++;
            $display("FAIL %s sel=%0d: got v=%b f=%b data=%h dest=%0d exp v=1 f=0 data=%h dest=%0d",
                     t, s, rd_valid, flag_valid, rd_data, rd_dest, ev, d);
         end
      end else if (k == 2) begin
         if (!(flag_valid && !rd_valid && flag_nzcv == ev[31:28])) begin
            errors++;
            $display("FAIL %s flags: got f=%b v=%b nzcv=%h exp f=1 v=0 nzcv=%h",
                     t, flag_valid, rd_valid, flag_nzcv, ev[31:28]);
         end
      end else begin
         if (rd_valid || flag_valid || rd_data != 0) begin
            errors++;
            $display("FAIL %s sel=%0d ignored: got v=%b f=%b data=%h exp v=0 f=0 data=0",
                     t, s, rd_valid, flag_valid, rd_data);
         end
      end
      req_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state of outputs
      checks++;
      if (rd_valid || flag_valid || rd_data != 0) begin
         errors++;
         $display("FAIL R8 reset: got v=%b f=%b data=%h exp 0 0 0", rd_valid, flag_valid, rd_data);
      end
      // R5 reset values read with privilege
      req(1, 0, 9, 3, 0, 4'hE, 0, 1);
      req(1, 0, 10, 4, 0, 4'hE, 0, 1);
      req(1, 0, 8, 5, 0, 4'hE, 0, 1);
      req(1, 0, 1, 6, 0, 4'hE, 0, 0);
      // R2 constants in user mode
      req(1, 0, 0, 1, 0, 4'hE, 0, 0);
      req(1, 0, 7, 2, 0, 4'hE, 0, 0);
      req(1, 0, 6, 2, 0, 4'hE, 0, 0);
      // R1 and R4: status write, readback, flag transfer
      req(1, 1, 1, 0, 32'hA000_1234, 4'hE, 0, 0);
      req(1, 0, 1, 7, 0, 4'hE, 0, 0);
      req(1, 0, 1, 15, 0, 4'hE, 0, 0);
      req(1, 1, 1, 0, 32'h5FFF_FFFF, 4'h0, 1, 0);
      req(1, 0, 1, 15, 0, 4'h3, 1, 1);
      // R3: unprivileged write then privileged read shows no change
      req(1, 1, 9, 0, 32'hDEAD_BEEF, 4'hE, 0, 0);
      req(1, 0, 9, 8, 0, 4'hE, 0, 0);
      req(1, 0, 9, 8, 0, 4'hE, 0, 1);
      req(1, 1, 10, 0, 32'h1234_5678, 4'hE, 0, 1);
      req(1, 0, 10, 9, 0, 4'hE, 0, 1);
      // R6: condition failed write then read back
      req(1, 1, 1, 0, 32'hFFFF_0000, 4'h2, 0, 0);
      req(1, 0, 1, 1, 0, 4'hE, 0, 0);
      // R7: read-only and unused selectors
      req(1, 1, 0, 0, 32'h0, 4'hE, 0, 1);
      req(1, 0, 0, 3, 0, 4'hE, 0, 1);
      req(1, 1, 7, 0, 32'h0, 4'hE, 0, 1);
      req(1, 0, 7, 3, 0, 4'hE, 0, 1);
      req(1, 0, 4, 3, 0, 4'hE, 0, 1);
      req(1, 0, 13, 3, 0, 4'hE, 0, 1);
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [3:0] c, d;
         c = ($urandom_range(0, 1) == 0) ? 4'hE : 4'($urandom);
         d = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom);
         req(1'($urandom_range(0, 7) != 0), 1'($urandom), 4'($urandom), d, $urandom,
             c, 1'($urandom), 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule